// File: doc/BRIEF.md
# Multi-Mode Timer with Compare Outputs

A 16-bit timer with a power-of-two clock divider and two compare channels. The counter can run as a sawtooth (counts up, then restarts at zero), as a triangle (counts up, then back down), or in a density mode. In density mode each channel turns its compare value into a one-bit pulse-density stream. Averaged over the period value, the fraction of ones equals compare divided by period, so a simple RC filter on the pin gives a DAC. In the two counting modes each channel drives a PWM pin. The triangle mode gives center-aligned PWM. The timer also raises a one-cycle period event and one-cycle compare-hit pulses.

Software reaches the block through a byte-wide register port. Double buffering can be switched on. The period and compare values then move to their active copies only when the counter goes back to zero, so a new frequency or duty cycle never cuts a running cycle short. High-byte holding can also be switched on. It makes 16-bit accesses atomic over the 8-bit bus: a high-byte write waits for the low-byte write, and a low-byte read freezes the high byte for the read that follows.

Top module: `mmtmr_top`

## Requirements
- R1: Register addresses are 0 control, 1/2 period low/high, 3/4 counter low/high, 5/6 compare-0 low/high, 7/8 compare-1 low/high. Control bits [1:0] select the mode (0 stopped, 1 sawtooth, 2 triangle, 3 density), bits [4:2] select the divider exponent, bit 5 turns on double buffering and bit 6 turns on high-byte holding. Control reads back as written, with bit 7 always 0.
- R2: After reset every register is zero, the timer is stopped, all pins and pulses are low, and `bus_rdata` is 0 whenever `bus_rd` is low.
- R3: In sawtooth mode the counter steps 0,1,…,P,0 on each divider tick, where P is the active period. `period_evt_o` is high for one cycle in the cycle in which the counter has just returned to 0.
- R4: In triangle mode the counter steps 0,1,…,P,P-1,…,0, so one cycle lasts 2·P ticks. `period_evt_o` pulses in the cycle in which the down slope has just reached 0.
- R5: In sawtooth and triangle modes, `pwm_o[i]` is high exactly while count < active compare i. `cmp_evt_o[i]` pulses for one cycle when a tick has just moved the counter onto compare i.
- R6: In density mode, with compare ≤ period and period > 0, any P consecutive ticks put exactly compare-i ones on `pwm_o[i]`. The stream starts from a cleared accumulator on entering the mode and is valid from the cycle after the first tick.
- R7: With divider exponent n, the counter steps once every 2^n clocks. The first step comes 2^n clocks after the mode leaves stopped.
- R8: While double buffering is on, period and compare writes go to shadow copies and become active on the tick that returns the counter to 0. While it is off, a write becomes active at once.
- R9: While high-byte holding is on, a high-byte write is held and commits together with the next low-byte write. A low-byte read latches the high byte of that register, and a high-byte read returns the latched byte.
- R10: While high-byte holding is off, each byte write updates its half of the register at once, and high-byte reads return the live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; also latches the high byte on low-byte reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pwm_o | output | NCH | Per-channel PWM or density output |
| period_evt_o | output | 1 | One-cycle pulse when the counter returns to zero |
| cmp_evt_o | output | NCH | One-cycle pulse when a tick lands on the channel's compare value |

## Verification
The bench builds the block with its defaults: a 16-bit counter, two channels and a 3-bit divider exponent. With two channels, independent compare values can be checked side by side in every mode, including a compare equal to the period and a density pair whose ones sum to the period. The divider exponent is exercised at 0 and 2, and control readback covers the largest exponent. A counter preset just below a byte boundary lets the bench prove that a held high byte differs from the live one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int PS_W = 3;

   typedef enum logic [1:0] {
      TM_OFF = 2'd0,
      TM_SAW = 2'd1,
      TM_TRI = 2'd2,
      TM_SDM = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic            hib;
      logic            dbuf;
      logic [PS_W-1:0] ps;
      tmr_mode_e       mode;
   } tmr_ctrl_t;

   localparam logic [3:0] A_CTRL  = 4'd0;
   localparam logic [3:0] A_PER_L = 4'd1;
   localparam logic [3:0] A_CNT_L = 4'd3;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [PS_W-1:0] ps,
   output logic            tick
);
   localparam int DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] pcnt;
   logic [DIV_W-1:0] mask;

   assign mask = ~({DIV_W{1'b1}} << ps);
   assign tick = en && ((pcnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) pcnt <= '0;
      else               pcnt <= pcnt + 1'b1;
   end

   AST_PS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ps != '0) |=> (!tick || ps != $past(ps))); // R7
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_mode_e        mode,
   input  logic             tick,
   input  logic [CNT_W-1:0] per,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             step,
   output logic             evt,
   output logic             wrap_now
);
   logic             up;
   logic             up_n;
   logic             zero;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      nxt  = cnt;
      up_n = up;
      zero = 1'b0;
      if (mode == TM_TRI) begin
         if (up && cnt < per) begin
            nxt = cnt + 1'b1;
         end else if (cnt == '0) begin
            zero = 1'b1;
            up_n = 1'b1;
         end else begin
            nxt  = cnt - 1'b1;
            zero = (cnt == CNT_W'(1));
            up_n = zero;
         end
      end else if (cnt >= per) begin
         nxt  = '0;
         zero = 1'b1;
      end else begin
         nxt = cnt + 1'b1;
      end
   end

   assign wrap_now = tick && !ld && zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         up   <= 1'b1;
         step <= 1'b0;
         evt  <= 1'b0;
      end else begin
         step <= 1'b0;
         evt  <= 1'b0;
         if (ld) begin
            cnt <= ld_val;
         end else if (tick) begin
            cnt  <= nxt;
            up   <= up_n;
            step <= 1'b1;
            evt  <= zero;
         end
         if (mode == TM_OFF) up <= 1'b1;
      end
   end

   AST_SAW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && mode == TM_SAW && cnt >= per) |=> (cnt == '0 && evt)); // R3
   AST_TRI_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld && mode == TM_TRI && up && cnt >= per && cnt > CNT_W'(1))
      |=> (!up && cnt == $past(cnt) - 1'b1)); // R4
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_mode_e        mode,
   input  logic             tick,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] per,
   input  logic [CNT_W-1:0] cmp,
   output logic             pwm,
   output logic             hit
);
   localparam int ACC_W = CNT_W + 1;

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] sum;
   logic             sd_q;
   logic             counting;

   assign sum      = acc + {1'b0, cmp};
   assign counting = (mode == TM_SAW) || (mode == TM_TRI);

   always_ff @(posedge clk) begin
      if (!rst_n || mode != TM_SDM) begin
         acc  <= '0;
         sd_q <= 1'b0;
      end else if (tick) begin
         if (sum >= {1'b0, per}) begin
            sd_q <= 1'b1;
            acc  <= sum - {1'b0, per};
         end else begin
            sd_q <= 1'b0;
            acc  <= sum;
         end
      end
   end

   assign pwm = (mode == TM_SDM) ? sd_q : (counting && cnt < cmp);
   assign hit = step && counting && (cnt == cmp);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int NCH   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [3:0]                addr,
   input  logic                      wr,
   input  logic                      rd,
   input  logic [7:0]                wdata,
   output logic [7:0]                rdata,
   input  logic [CNT_W-1:0]          cnt,
   input  logic                      wrap_now,
   output tmr_ctrl_t                 ctrl,
   output logic [CNT_W-1:0]          per_act,
   output logic [NCH-1:0][CNT_W-1:0] cmp_act,
   output logic                      cnt_ld,
   output logic [CNT_W-1:0]          cnt_ld_val
);
   localparam int NREG  = 2 + NCH;
   localparam int NSLOT = 8;

   logic [CNT_W-1:0]            per_sh;
   logic [NCH-1:0][CNT_W-1:0]   cmp_sh;
   logic [NSLOT-1:0][CNT_W-1:0] cur;
   logic [7:0]                  wr_hold;
   logic [7:0]                  rd_hold;
   logic [3:0]                  aoff;
   logic [2:0]                  idx;
   logic                        in_rng;
   logic                        is_lo;
   logic [CNT_W-1:0]            sel;
   logic [CNT_W-1:0]            wval;
   logic [NSLOT-1:0]            we;

   for (genvar j = 0; j < NSLOT; j++) begin : g_slot
      if (j == 0)         begin : g_per  assign cur[j] = per_sh;       end
      else if (j == 1)    begin : g_cnt  assign cur[j] = cnt;          end
      else if (j < NREG)  begin : g_cmp  assign cur[j] = cmp_sh[j-2];  end
      else                begin : g_none assign cur[j] = '0;           end
   end

   assign aoff   = addr - 4'd1;
   assign idx    = aoff[3:1];
   assign in_rng = (addr != A_CTRL) && (int'(idx) < NREG);
   assign is_lo  = addr[0];
   assign sel    = cur[idx];

   always_comb begin
      if (!is_lo)        wval = {wdata, sel[7:0]};
      else if (ctrl.hib) wval = {wr_hold, wdata};
      else               wval = {sel[CNT_W-1 -: 8], wdata};
      for (int j = 0; j < NSLOT; j++)
         we[j] = wr && in_rng && (int'(idx) == j) && (is_lo || !ctrl.hib);
   end

   assign cnt_ld     = we[1];
   assign cnt_ld_val = wval;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl    <= '0;
         per_sh  <= '0;
         per_act <= '0;
         wr_hold <= '0;
         rd_hold <= '0;
      end else begin
         if (wr && addr == A_CTRL) ctrl <= tmr_ctrl_t'(wdata[6:0]);
         if (wr && in_rng && !is_lo && ctrl.hib) wr_hold <= wdata;
         if (rd && in_rng && is_lo) rd_hold <= sel[CNT_W-1 -: 8];
         if (we[0]) per_sh <= wval;
         if (we[0] && !ctrl.dbuf) per_act <= wval;
         else if (wrap_now)       per_act <= per_sh;
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_cmpreg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cmp_sh[i]  <= '0;
            cmp_act[i] <= '0;
         end else begin
            if (we[2+i]) cmp_sh[i] <= wval;
            if (we[2+i] && !ctrl.dbuf) cmp_act[i] <= wval;
            else if (wrap_now)         cmp_act[i] <= cmp_sh[i];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         if (addr == A_CTRL) rdata = {1'b0, ctrl};
         else if (in_rng)    rdata = is_lo ? sel[7:0]
                                   : (ctrl.hib ? rd_hold : sel[CNT_W-1 -: 8]);
      end
   end

   AST_DBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.dbuf && we[0] && !wrap_now) |=> $stable(per_act)); // R8
   AST_HIB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ctrl.hib && addr == A_PER_L + 4'd1) |=> $stable(per_sh)); // R9
endmodule

// File: rtl/mmtmr_top.sv
module mmtmr_top
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int NCH   = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [3:0]     bus_addr,
   input  logic           bus_wr,
   input  logic           bus_rd,
   input  logic [7:0]     bus_wdata,
   output logic [7:0]     bus_rdata,
   output logic [NCH-1:0] pwm_o,
   output logic           period_evt_o,
   output logic [NCH-1:0] cmp_evt_o
);
   if (CNT_W != 16) begin : g_bad_width
      $error("mmtmr_top: CNT_W must be 16 for the byte-pair register layout");
   end
   if (NCH < 1 || NCH > 2) begin : g_bad_nch
      $error("mmtmr_top: NCH must be 1 or 2 to fit the address map");
   end

   tmr_ctrl_t                 ctrl;
   logic [CNT_W-1:0]          per_act;
   logic [NCH-1:0][CNT_W-1:0] cmp_act;
   logic                      cnt_ld;
   logic [CNT_W-1:0]          cnt_ld_val;
   logic [CNT_W-1:0]          cnt;
   logic                      tick;
   logic                      step;
   logic                      wrap_now;

   tmr_regs #(.CNT_W(CNT_W), .NCH(NCH)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt), .wrap_now(wrap_now),
      .ctrl(ctrl), .per_act(per_act), .cmp_act(cmp_act),
      .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val)
   );

   tmr_presc #(.PS_W(PS_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .en(ctrl.mode != TM_OFF), .ps(ctrl.ps), .tick(tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .mode(ctrl.mode), .tick(tick), .per(per_act),
      .ld(cnt_ld), .ld_val(cnt_ld_val), .cnt(cnt), .step(step),
      .evt(period_evt_o), .wrap_now(wrap_now)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      tmr_chan #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .mode(ctrl.mode), .tick(tick), .step(step),
         .cnt(cnt), .per(per_act), .cmp(cmp_act[i]),
         .pwm(pwm_o[i]), .hit(cmp_evt_o[i])
      );
   end
endmodule

// File: tb/mmtmr_top_tb_top.sv
module mmtmr_top_tb_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] pwm_o;
   logic       period_evt_o;
   logic [1:0] cmp_evt_o;

   int nvec = 0;
   int nfail = 0;

   always #(CLK_P/2) clk = ~clk;

   mmtmr_top #(.CNT_W(16), .NCH(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_o(pwm_o), .period_evt_o(period_evt_o), .cmp_evt_o(cmp_evt_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set16(input logic [3:0] lo, input logic [15:0] v);
      wr(lo + 4'd1, v[15:8]);
      wr(lo, v[7:0]);
   endtask

   task automatic check_wave(input bit tri_m, input int per, input int c0, input int c1, input int nk);
      for (int k = 0; k <= nk; k++) begin
         int e;
         int p;
         if (tri_m) begin
            p = k % (2*per);
            e = (p <= per) ? p : 2*per - p;
         end else begin
            e = k % (per + 1);
         end
         chk(tri_m ? "R4 period event" : "R3 period event", period_evt_o, (k > 0 && e == 0));
         chk("R5 pwm ch0", pwm_o[0], (e < c0));
         chk("R5 pwm ch1", pwm_o[1], (e < c1));
         chk("R5 hit ch0", cmp_evt_o[0], (k > 0 && e == c0));
         chk("R5 hit ch1", cmp_evt_o[1], (k > 0 && e == c1));
         idle();
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R2 idle rdata", bus_rdata, 0);
      chk("R2 pwm", pwm_o, 0);
      chk("R2 event", period_evt_o, 0);
      rd(4'd0, d); chk("R2 control", d, 0);
      rd(4'd1, d); chk("R2 period low", d, 0);
      rd(4'd6, d); chk("R2 compare0 high", d, 0);
   endtask

   task automatic t_map();
      logic [7:0] d;
      wr(4'd0, 8'h7C); rd(4'd0, d); chk("R1 control readback", d, 'h7C);
      wr(4'd0, 8'hFC); rd(4'd0, d); chk("R1 control bit7 zero", d, 'h7C);
      wr(4'd0, 8'h00);
      wr(4'd7, 8'hA5); rd(4'd7, d); chk("R1 compare1 low", d, 'hA5);
      wr(4'd8, 8'h3C); rd(4'd8, d); chk("R1 compare1 high", d, 'h3C);
   endtask

   task automatic t_saw();
      wr(4'd0, 8'h00);
      set16(4'd1, 16'd4); set16(4'd5, 16'd2); set16(4'd7, 16'd4); set16(4'd3, 16'd0);
      wr(4'd0, 8'h01);
      check_wave(1'b0, 4, 2, 4, 11); // R3 R5
   endtask

   task automatic t_tri();
      wr(4'd0, 8'h00);
      set16(4'd1, 16'd3); set16(4'd5, 16'd1); set16(4'd7, 16'd3); set16(4'd3, 16'd0);
      wr(4'd0, 8'h02);
      check_wave(1'b1, 3, 1, 3, 13); // R4 R5
   endtask

   task automatic t_presc();
      wr(4'd0, 8'h00);
      set16(4'd1, 16'd100); set16(4'd5, 16'd5); set16(4'd7, 16'd0); set16(4'd3, 16'd0);
      wr(4'd0, 8'h09);
      for (int k = 0; k <= 24; k++) begin
         chk("R7 hit after 20 clocks", cmp_evt_o[0], (k == 20));
         chk("R7 pwm divided", pwm_o[0], (k < 20));
         idle();
      end
   endtask

   task automatic t_sd();
      wr(4'd0, 8'h00);
      set16(4'd1, 16'd10); set16(4'd5, 16'd3); set16(4'd7, 16'd7);
      wr(4'd0, 8'h03);
      idle();
      for (int w = 0; w < 2; w++) begin
         int n0 = 0;
         int n1 = 0;
         for (int k = 0; k < 10; k++) begin
            n0 += pwm_o[0];
            n1 += pwm_o[1];
            idle();
         end
         chk("R6 density ch0", n0, 3);
         chk("R6 density ch1", n1, 7);
      end
   endtask

   task automatic t_dbuf();
      wr(4'd0, 8'h00);
      set16(4'd1, 16'd9); set16(4'd5, 16'd5); set16(4'd7, 16'd0); set16(4'd3, 16'd0);
      wr(4'd0, 8'h21);
      wr(4'd5, 8'd1);
      chk("R8 compare held", pwm_o[0], 1);
      wr(4'd6 - 4'd5, 8'd4);
      for (int k = 2; k <= 16; k++) begin
         int e = (k < 10) ? k : (k - 10) % 5;
         int c = (k < 10) ? 5 : 1;
         chk("R8 pwm with buffered compare", pwm_o[0], (e < c));
         chk("R8 event with buffered period", period_evt_o, (k == 10 || k == 15));
         idle();
      end
   endtask

   task automatic t_hib();
      logic [7:0] d;
      wr(4'd0, 8'h00);
      set16(4'd1, 16'd0);
      wr(4'd0, 8'h40);
      wr(4'd2, 8'h12);
      rd(4'd1, d); chk("R9 low before commit", d, 'h00);
      rd(4'd2, d); chk("R9 high held back", d, 'h00);
      wr(4'd1, 8'h34);
      rd(4'd1, d); chk("R9 low committed", d, 'h34);
      rd(4'd2, d); chk("R9 high committed", d, 'h12);
      set16(4'd3, 16'h00FE);
      set16(4'd1, 16'hFFFF);
      wr(4'd0, 8'h41);
      rd(4'd3, d); chk("R9 counter low", d, 'hFE);
      idle();
      rd(4'd4, d); chk("R9 counter high latched", d, 'h00);
      wr(4'd0, 8'h00);
   endtask

   task automatic t_nohib();
      logic [7:0] d;
      wr(4'd0, 8'h00);
      set16(4'd1, 16'd0);
      wr(4'd2, 8'h05);
      rd(4'd2, d); chk("R10 high immediate", d, 'h05);
      rd(4'd1, d); chk("R10 low untouched", d, 'h00);
      wr(4'd1, 8'h77);
      rd(4'd1, d); chk("R10 low immediate", d, 'h77);
      rd(4'd2, d); chk("R10 high kept", d, 'h05);
   endtask

   initial begin : wdog
      #(CLK_P * 150000);
      nfail++;
      $display("FAIL all requirements: watchdog expired, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_saw();
      t_tri();
      t_presc();
      t_sd();
      t_dbuf();
      t_hib();
      t_nohib();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule